// File: doc/BRIEF.md
# Sparse I/O Window Address Translator

This block connects a processor-side request/response bus to a legacy I/O port space that is 16 bits wide in its flat form. Each processor access is checked against an 8 MB aperture based at 0x8000_0000. Only the offset inside that aperture is turned into a port number, which leaves the block on a 20-bit port address bus. A one-bit map-type register picks the translation. In flat mode the port is simply the low 16 offset bits. In sparse mode each 4 KB page of the aperture carries 32 ports. The map-type register can be changed while the block is running and acts from the next transaction onward.

The processor is big-endian and the devices are little-endian. For that reason the block reverses byte lanes on halfword and word transfers, in both directions, and passes byte transfers through unchanged. The map-type register and a dummy cache-flush port are handled inside the block and are never forwarded. Accesses outside the aperture and illegal size codes get an error response. The block handles one transaction at a time and keeps its ready line low until the current transaction has been answered.

Top module: `sparse_io_xlate`

## Requirements
- R1: An address in the range [0x8000_0000, 0x8080_0000) is translated. Any other address is not forwarded (io_valid stays low), and the block responds with rsp_err=1 and rsp_rdata=0xFFFF_FFFF.
- R2: When the map-type bit is 0, io_addr equals window offset bits [15:0], zero-extended to 20 bits.
- R3: When the map-type bit is 1, io_addr[4:0] equals offset[4:0] and io_addr[19:5] equals offset[26:12]. Offset bits [11:5] have no effect on the port.
- R4: The map-type register is the translated port 0x850 and is handled locally, with no forwarding. A write stores bit 0 of the lane-adjusted write data. A byte read returns the stored bit in bit 0 and zeros in all other bits. The bit resets to 1, and a write changes the translation of the next transaction.
- R5: Port 0x814 is handled locally. A read returns zero, a write is absorbed, and nothing is forwarded.
- R6: req_size 0 is a byte transfer. io_size is 1 and data travels in bits [7:0] with no lane swap. The upper read-data bits return as zero.
- R7: req_size 1 is a halfword transfer. io_size is 2, and the two low bytes are exchanged on write data and on read data. The upper 16 read bits return as zero.
- R8: req_size 2 is a word transfer. io_size is 4, and all four bytes are reversed on write data and on read data.
- R9: After an access is accepted, req_ready stays low until rsp_valid. While io_valid is high and io_done is low, io_valid, io_addr and io_wdata hold steady. rsp_valid is high for exactly one cycle, and rsp_rdata is zero for writes.
- R10: A req_size of 3 gets the same error response as R1 and is not forwarded.
- R11: While reset is held, req_ready is 1, io_valid is 0 and rsp_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Processor request present |
| req_ready | output | 1 | Block can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Processor byte address |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 illegal |
| req_wdata | input | 32 | Write data, big-endian lanes |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_err | output | 1 | Access rejected |
| rsp_rdata | output | 32 | Read data, big-endian lanes |
| io_valid | output | 1 | Port transaction pending |
| io_write | output | 1 | Port write when high |
| io_addr | output | 20 | Port address |
| io_size | output | 3 | Port transfer bytes: 1, 2 or 4 |
| io_wdata | output | 32 | Port write data, little-endian lanes |
| io_done | input | 1 | Port side has completed the transaction |
| io_rdata | input | 32 | Port read data, valid with io_done |

## Verification
The bench sends the same offsets through both maps. For example, offset 0x42010 reaches the map-type register in sparse mode but goes to port 0x2010 in flat mode. A folder that kept offset bits [11:5], shifted by the wrong amount, or ignored the mode would route these to the wrong ports. It flips the mode and reads it back under the other map, and it resets after a mode change to show the bit returns to 1. A register that updated late or reset to 0 would then give the wrong translation. Halfword reads with non-zero upper bus bits, and word writes with distinct bytes, catch a swapper that reverses the wrong lane count or lets stale upper bytes through. Addresses just outside each end of the aperture, and size code 3, must come back as errors with all-ones data and no port strobe.

// File: rtl/sxl_pkg.sv
// Shared types for the sparse I/O translator.
// Assumes processor transfers are at most four bytes wide.
package sxl_pkg;

    // Processor-side transfer size code
    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_BAD  = 2'd3
    } xfer_size_e;

    // Transaction sequencer states
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_RESP = 2'd2
    } seq_state_e;

    // Byte count of a size code; zero for the illegal code
    function automatic logic [2:0] size_bytes(xfer_size_e s);
        case (s)
            SZ_BYTE: size_bytes = 3'd1;
            SZ_HALF: size_bytes = 3'd2;
            SZ_WORD: size_bytes = 3'd4;
            default: size_bytes = 3'd0;
        endcase
    endfunction

endpackage

// File: rtl/sxl_addr_fold.sv
// Aperture check and address folding.
// The window is aligned to its own size (WIN_BASE has zeros below WIN_BITS).
// sparse=0: port = low FLAT_BITS of the offset.
// sparse=1: port = {offset >> PAGE_SHIFT, offset[KEEP_BITS-1:0]}.
// Purely combinational.
module sxl_addr_fold #(
    parameter int          ADDR_W     = 32,
    parameter logic [31:0] WIN_BASE   = 32'h8000_0000,
    parameter int          WIN_BITS   = 23,
    parameter int          PORT_W     = 20,
    parameter int          FLAT_BITS  = 16,
    parameter int          PAGE_SHIFT = 12,
    parameter int          KEEP_BITS  = 5
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              sparse,
    output logic              in_win,
    output logic [PORT_W-1:0] port
);
    localparam int PAGE_W = WIN_BITS - PAGE_SHIFT;
    localparam int FOLD_W = PAGE_W + KEEP_BITS;

    logic [WIN_BITS-1:0] offset;
    logic [PAGE_W-1:0]   page_idx;
    logic [FOLD_W-1:0]   folded;
    logic [PORT_W-1:0]   flat_port;
    logic [PORT_W-1:0]   sparse_port;

    // Split the offset and compare the upper bits against the window base
    always_comb begin
        offset      = addr[WIN_BITS-1:0];
        in_win      = (addr[ADDR_W-1:WIN_BITS] == WIN_BASE[ADDR_W-1:WIN_BITS]);
        page_idx    = offset[WIN_BITS-1:PAGE_SHIFT];
        folded      = {page_idx, offset[KEEP_BITS-1:0]};
        flat_port   = PORT_W'(offset[FLAT_BITS-1:0]);
        sparse_port = PORT_W'(folded);
        port        = sparse ? sparse_port : flat_port;
    end

endmodule

// File: rtl/sxl_lane_swap.sv
// Byte-lane reversal over the low N bytes, where N comes from the size code.
// Lanes at or above N are driven to zero. The illegal size code gives zero.
// The same unit serves write data and read data, because reversal is its own inverse.
module sxl_lane_swap
    import sxl_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic [LANES*8-1:0] din,
    input  xfer_size_e         size,
    output logic [LANES*8-1:0] dout
);
    // Reverse the active lanes and clear the idle ones
    always_comb begin
        int n;
        n    = int'(size_bytes(size));
        dout = '0;
        for (int i = 0; i < LANES; i++) begin
            if (i < n) begin
                dout[8*i +: 8] = din[8*(n-1-i) +: 8];
            end
        end
    end

endmodule

// File: rtl/sxl_map_reg.sv
// One-bit map-type register: 1 = sparse folding, 0 = flat folding.
// Resets to sparse. Any change shows from the cycle after a write strobe.
module sxl_map_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  logic wr_bit,
    output logic sparse
);
    // Hold the map-type bit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sparse <= 1'b1;
        end else if (wr_en) begin
            sparse <= wr_bit;
        end
    end

    // The mode moves only because of a write strobe
    assert_mode_by_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sparse) |-> $past(wr_en));

endmodule

// File: rtl/sparse_io_xlate.sv
// Translates processor accesses in an I/O aperture into port transactions.
// One transaction at a time. Ports at MAP_PORT and L2_PORT are handled locally.
// Assumes the port side eventually raises io_done for every io_valid.
module sparse_io_xlate
    import sxl_pkg::*;
#(
    parameter int          ADDR_W     = 32,
    parameter int          DATA_W     = 32,
    parameter int          PORT_W     = 20,
    parameter logic [31:0] WIN_BASE   = 32'h8000_0000,
    parameter int          WIN_BITS   = 23,
    parameter int          FLAT_BITS  = 16,
    parameter int          PAGE_SHIFT = 12,
    parameter int          KEEP_BITS  = 5,
    parameter logic [19:0] MAP_PORT   = 20'h00850,
    parameter logic [19:0] L2_PORT    = 20'h00814
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_size,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              io_valid,
    output logic              io_write,
    output logic [PORT_W-1:0] io_addr,
    output logic [2:0]        io_size,
    output logic [DATA_W-1:0] io_wdata,
    input  logic              io_done,
    input  logic [DATA_W-1:0] io_rdata
);
    localparam int LANES = DATA_W / 8;

    seq_state_e        state;
    xfer_size_e        req_sz;
    xfer_size_e        size_q;
    logic              sparse;
    logic              in_win;
    logic [PORT_W-1:0] port;
    logic              accept;
    logic              bad_req;
    logic              hit_map;
    logic              hit_l2;
    logic              map_wr;
    logic [DATA_W-1:0] wr_swap;
    logic [DATA_W-1:0] rd_in;
    logic [DATA_W-1:0] rd_swap;
    xfer_size_e        rd_size;
    logic              io_write_q;
    logic [PORT_W-1:0] io_addr_q;
    logic [2:0]        io_size_q;
    logic [DATA_W-1:0] io_wdata_q;
    logic [DATA_W-1:0] rsp_rdata_q;
    logic              rsp_err_q;

    sxl_map_reg u_map (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (map_wr),
        .wr_bit (wr_swap[0]),
        .sparse (sparse)
    );

    sxl_addr_fold #(
        .ADDR_W     (ADDR_W),
        .WIN_BASE   (WIN_BASE),
        .WIN_BITS   (WIN_BITS),
        .PORT_W     (PORT_W),
        .FLAT_BITS  (FLAT_BITS),
        .PAGE_SHIFT (PAGE_SHIFT),
        .KEEP_BITS  (KEEP_BITS)
    ) u_fold (
        .addr   (req_addr),
        .sparse (sparse),
        .in_win (in_win),
        .port   (port)
    );

    sxl_lane_swap #(.LANES(LANES)) u_wr_swap (
        .din  (req_wdata),
        .size (req_sz),
        .dout (wr_swap)
    );

    sxl_lane_swap #(.LANES(LANES)) u_rd_swap (
        .din  (rd_in),
        .size (rd_size),
        .dout (rd_swap)
    );

    // Decode the incoming request and pick the read-swap source
    always_comb begin
        req_sz  = xfer_size_e'(req_size);
        accept  = (state == ST_IDLE) && req_valid;
        bad_req = !in_win || (req_sz == SZ_BAD);
        hit_map = (port == PORT_W'(MAP_PORT));
        hit_l2  = (port == PORT_W'(L2_PORT));
        map_wr  = accept && !bad_req && hit_map && req_write;
        rd_in   = (state == ST_WAIT) ? io_rdata : DATA_W'(sparse);
        rd_size = (state == ST_WAIT) ? size_q : req_sz;
    end

    // Sequence one transaction: accept, optionally wait on the port, respond
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_IDLE;
            size_q      <= SZ_BYTE;
            io_write_q  <= 1'b0;
            io_addr_q   <= '0;
            io_size_q   <= '0;
            io_wdata_q  <= '0;
            rsp_rdata_q <= '0;
            rsp_err_q   <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        size_q     <= req_sz;
                        io_write_q <= req_write;
                        if (bad_req) begin
                            rsp_err_q   <= 1'b1;
                            rsp_rdata_q <= '1;
                            state       <= ST_RESP;
                        end else if (hit_map || hit_l2) begin
                            rsp_err_q   <= 1'b0;
                            rsp_rdata_q <= (req_write || hit_l2) ? '0 : rd_swap;
                            state       <= ST_RESP;
                        end else begin
                            rsp_err_q  <= 1'b0;
                            io_addr_q  <= port;
                            io_size_q  <= size_bytes(req_sz);
                            io_wdata_q <= wr_swap;
                            state      <= ST_WAIT;
                        end
                    end
                end
                ST_WAIT: begin
                    if (io_done) begin
                        rsp_rdata_q <= io_write_q ? '0 : rd_swap;
                        state       <= ST_RESP;
                    end
                end
                default: begin
                    state <= ST_IDLE;
                end
            endcase
        end
    end

    // Drive the ports from the sequencer state and holding registers
    always_comb begin
        req_ready = (state == ST_IDLE);
        io_valid  = (state == ST_WAIT);
        io_write  = io_write_q;
        io_addr   = io_addr_q;
        io_size   = io_size_q;
        io_wdata  = io_wdata_q;
        rsp_valid = (state == ST_RESP);
        rsp_err   = rsp_err_q;
        rsp_rdata = rsp_rdata_q;
    end

    assert_busy_not_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
        io_valid |-> !req_ready);

    assert_io_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (io_valid && !io_done) |=> (io_valid && $stable(io_addr) && $stable(io_wdata)));

    assert_rsp_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    assert_err_all_ones_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_err) |-> (rsp_rdata == '1));

    assert_no_fwd_outside_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !in_win) |=> !io_valid);

    assert_no_fwd_bad_size_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && (req_sz == SZ_BAD)) |=> (!io_valid && rsp_err));

endmodule

// File: tb/sparse_io_xlate_tb.sv
`timescale 1ns/1ps
module sparse_io_xlate_tb;

    typedef struct packed {
        logic        wr;
        logic [31:0] addr;
        logic [1:0]  size;
        logic [31:0] wdata;
        logic        fwd;
        logic [19:0] io_addr;
        logic [2:0]  io_size;
        logic [31:0] io_wdata;
        logic [31:0] io_rdata;
        logic [31:0] rdata;
        logic        err;
    } vec_t;

    localparam int NV = 19;
    localparam longint WD_NS = 500000;

    // wr, addr, size, wdata, fwd, io_addr, io_size, io_wdata, io_rdata, rdata, err
    localparam vec_t VECS [NV] = '{
        '{1'b1, 32'h8000_1003, 2'd0, 32'h0000_00A5, 1'b1, 20'h00023, 3'd1, 32'h0000_00A5, 32'h0, 32'h0, 1'b0},
        '{1'b0, 32'h807F_F01F, 2'd2, 32'h0,         1'b1, 20'h0FFFF, 3'd4, 32'h0, 32'h1122_3344, 32'h4433_2211, 1'b0},
        '{1'b1, 32'h8003_4FE2, 2'd1, 32'h0000_BEEF, 1'b1, 20'h00682, 3'd2, 32'h0000_EFBE, 32'h0, 32'h0, 1'b0},
        '{1'b1, 32'h8012_3456, 2'd2, 32'h0102_0304, 1'b1, 20'h02476, 3'd4, 32'h0403_0201, 32'h0, 32'h0, 1'b0},
        '{1'b0, 32'h8000_5000, 2'd1, 32'h0,         1'b1, 20'h000A0, 3'd2, 32'h0, 32'hFFFF_1234, 32'h0000_3412, 1'b0},
        '{1'b0, 32'h8080_0000, 2'd2, 32'h0,         1'b0, 20'h0, 3'd0, 32'h0, 32'h0, 32'hFFFF_FFFF, 1'b1},
        '{1'b1, 32'h7FFF_FFFF, 2'd0, 32'h0000_0011, 1'b0, 20'h0, 3'd0, 32'h0, 32'h0, 32'hFFFF_FFFF, 1'b1},
        '{1'b0, 32'h8004_2010, 2'd0, 32'h0,         1'b0, 20'h0, 3'd0, 32'h0, 32'h0, 32'h0000_0001, 1'b0},
        '{1'b0, 32'h8004_0014, 2'd0, 32'h0,         1'b0, 20'h0, 3'd0, 32'h0, 32'h0, 32'h0, 1'b0},
        '{1'b1, 32'h8004_2010, 2'd0, 32'h0000_00FE, 1'b0, 20'h0, 3'd0, 32'h0, 32'h0, 32'h0, 1'b0},
        '{1'b0, 32'h8000_0850, 2'd0, 32'h0,         1'b0, 20'h0, 3'd0, 32'h0, 32'h0, 32'h0, 1'b0},
        '{1'b0, 32'h8000_03F8, 2'd0, 32'h0,         1'b1, 20'h003F8, 3'd1, 32'h0, 32'hAABB_CC5A, 32'h0000_005A, 1'b0},
        '{1'b1, 32'h8012_ABCD, 2'd2, 32'hDEAD_BEEF, 1'b1, 20'h0ABCD, 3'd4, 32'hEFBE_ADDE, 32'h0, 32'h0, 1'b0},
        '{1'b0, 32'h8000_1003, 2'd1, 32'h0,         1'b1, 20'h01003, 3'd2, 32'h0, 32'h0000_8001, 32'h0000_0180, 1'b0},
        '{1'b0, 32'h8004_2010, 2'd0, 32'h0,         1'b1, 20'h02010, 3'd1, 32'h0, 32'h0000_0033, 32'h0000_0033, 1'b0},
        '{1'b1, 32'h8000_0850, 2'd0, 32'h0000_0001, 1'b0, 20'h0, 3'd0, 32'h0, 32'h0, 32'h0, 1'b0},
        '{1'b0, 32'h8000_1003, 2'd0, 32'h0,         1'b1, 20'h00023, 3'd1, 32'h0, 32'h0000_0077, 32'h0000_0077, 1'b0},
        '{1'b0, 32'h8000_0010, 2'd3, 32'h0,         1'b0, 20'h0, 3'd0, 32'h0, 32'h0, 32'hFFFF_FFFF, 1'b1},
        '{1'b1, 32'h8004_0014, 2'd2, 32'h1234_5678, 1'b0, 20'h0, 3'd0, 32'h0, 32'h0, 32'h0, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [31:0] req_addr = '0;
    logic [1:0]  req_size = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid;
    logic        rsp_err;
    logic [31:0] rsp_rdata;
    logic        io_valid;
    logic        io_write;
    logic [19:0] io_addr;
    logic [2:0]  io_size;
    logic [31:0] io_wdata;
    logic        io_done = 1'b0;
    logic [31:0] io_rdata = '0;

    int n_chk = 0;
    int n_err = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    sparse_io_xlate u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_size  (req_size),
        .req_wdata (req_wdata),
        .rsp_valid (rsp_valid),
        .rsp_err   (rsp_err),
        .rsp_rdata (rsp_rdata),
        .io_valid  (io_valid),
        .io_write  (io_write),
        .io_addr   (io_addr),
        .io_size   (io_size),
        .io_wdata  (io_wdata),
        .io_done   (io_done),
        .io_rdata  (io_rdata)
    );

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic string size_tag(input logic [1:0] s);
        case (s)
            2'd0: return "R6";
            2'd1: return "R7";
            2'd2: return "R8";
            default: return "R10";
        endcase
    endfunction

    task automatic run_vec(input vec_t v);
        string dtag;
        dtag = v.fwd ? size_tag(v.size) : (v.err ? "R1/R10" : "R4/R5");
        @(negedge clk);
        req_valid = 1'b1;
        req_write = v.wr;
        req_addr  = v.addr;
        req_size  = v.size;
        req_wdata = v.wdata;
        @(negedge clk);
        req_valid = 1'b0;
        if (v.fwd) begin
            chk("R9", "io_valid", 32'(io_valid), 32'd1);
            chk("R9", "req_ready busy", 32'(req_ready), 32'd0);
            chk("R2/R3", "io_addr", 32'(io_addr), 32'(v.io_addr));
            chk(size_tag(v.size), "io_size", 32'(io_size), 32'(v.io_size));
            chk("R9", "io_write", 32'(io_write), 32'(v.wr));
            if (v.wr) chk(size_tag(v.size), "io_wdata", io_wdata, v.io_wdata);
            @(negedge clk);
            chk("R9", "io_valid held", 32'(io_valid), 32'd1);
            chk("R9", "io_addr held", 32'(io_addr), 32'(v.io_addr));
            chk("R9", "no early rsp", 32'(rsp_valid), 32'd0);
            io_rdata = v.io_rdata;
            io_done  = 1'b1;
            @(negedge clk);
            io_done  = 1'b0;
            io_rdata = '0;
        end else begin
            chk("R1/R4/R5", "not forwarded", 32'(io_valid), 32'd0);
        end
        chk("R9", "rsp_valid", 32'(rsp_valid), 32'd1);
        chk("R1/R10", "rsp_err", 32'(rsp_err), 32'(v.err));
        chk(dtag, "rsp_rdata", rsp_rdata, v.rdata);
        @(negedge clk);
        chk("R9", "rsp one cycle", 32'(rsp_valid), 32'd0);
        chk("R9", "ready again", 32'(req_ready), 32'd1);
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary
    initial begin
        #(WD_NS);
        if (!finished) begin
            n_err++;
            n_chk++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        // R11: state while reset is held
        repeat (3) @(negedge clk);
        chk("R11", "req_ready in reset", 32'(req_ready), 32'd1);
        chk("R11", "io_valid in reset", 32'(io_valid), 32'd0);
        chk("R11", "rsp_valid in reset", 32'(rsp_valid), 32'd0);
        rst_n = 1'b1;

        // Table walk: sparse mode, flip to flat, flip back
        for (int i = 0; i < NV; i++) begin
            run_vec(VECS[i]);
        end

        // R4: switch to flat, reset, the bit must be sparse again
        run_vec(VECS[9]);
        run_vec(VECS[10]);
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk("R11", "req_ready in second reset", 32'(req_ready), 32'd1);
        rst_n = 1'b1;
        run_vec(VECS[7]);
        run_vec(VECS[0]);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule